// File: doc/BRIEF.md
# Ping-Pong Video Field Capture Controller

This block sits between a digital video decoder and two external byte-wide asynchronous SRAM banks. It runs in the decoder's pixel clock domain. It takes the 10-bit interleaved chroma/luma word stream, which repeats Cb, Y, Cr, Y, and keeps only the words marked as active video. The timing-reference code words sent before and after each line arrive with the active flag low, so they are never stored. Each kept word loses its two low bits and is written as one byte at an address that restarts from zero at the start of every active run.

Each bank holds one field. The odd/even field indicator arrives asynchronously and is synchronised into the pixel clock domain. Its value picks the bank that the capture side writes, and the host processor's address and control lines are routed to the other bank. When the indicator changes, the two banks trade roles, but only during blanking, so no write is ever split across a swap. At each swap the block pulses a field-complete flag for one cycle. With the pulse it gives the bank that now holds the finished field and the number of bytes written into it. The host can then read a whole field while the next one is being captured.

The address width is a parameter `ADDR_W`. Its default of 20 gives one mebibyte per bank.

Top module: `field_pingpong_capture`

## Requirements
- R1: When the synchronised field indicator accepted by the block is 1, bank 0 is the capture bank and bank 1 is the host bank. When it is 0, bank 1 captures and bank 0 serves the host. The host bank's write-enable is never driven low.
- R2: A change of `field_raw` passes through a two-flop synchroniser. It is accepted at a clock edge where the synchronised value differs from the accepted one and `vid_active` was low both at that edge and at the edge before. The banks swap in the cycle after that edge.
- R3: The first active word after `vid_active` was low is written to address 0, whatever was written before.
- R4: A word sampled with `vid_active` high is written during the next cycle. In that cycle the capture bank has `ce_n`=0, `we_n`=0 and `oe_n`=1, the address is the current write pointer and the data is `vid_word[9:2]`. The pointer then advances by 1.
- R5: A word sampled with `vid_active` low causes no write. In the next cycle the capture bank's `ce_n` and `we_n` are both 1.
- R6: The write pointer saturates at 2^ADDR_W−1. Further active words all go to that last address, and the reported length stays at 2^ADDR_W−1.
- R7: The host bank's address, `ce_n` and `oe_n` follow `host_addr`, `host_ce_n` and `host_oe_n` combinationally. `host_rdata` shows that bank's read data.
- R8: In the cycle after a swap is accepted, `field_done` is 1 for exactly one cycle. `field_len` then shows the write pointer at the swap, which is the byte count of the field unless it saturated, and `field_bank` shows the bank that captured that field (0 = bank 0). The pointer restarts at 0 for the new field.
- R9: While `rst` is high and after its release, the block accepts field value 0, so bank 1 is the capture bank with all strobes at 1, and `field_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel data clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_active | input | 1 | Active-video qualifier of the current word |
| vid_word | input | 10 | Decoder output word |
| field_raw | input | 1 | Asynchronous odd/even field indicator |
| host_addr | input | ADDR_W | Host address for the host bank |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_rdata | output | 8 | Read data of the host bank |
| bank0_addr | output | ADDR_W | Bank 0 address |
| bank0_wdata | output | 8 | Bank 0 write data |
| bank0_rdata | input | 8 | Bank 0 read data |
| bank0_ce_n | output | 1 | Bank 0 chip enable, active low |
| bank0_we_n | output | 1 | Bank 0 write enable, active low |
| bank0_oe_n | output | 1 | Bank 0 output enable, active low |
| bank1_addr | output | ADDR_W | Bank 1 address |
| bank1_wdata | output | 8 | Bank 1 write data |
| bank1_rdata | input | 8 | Bank 1 read data |
| bank1_ce_n | output | 1 | Bank 1 chip enable, active low |
| bank1_we_n | output | 1 | Bank 1 write enable, active low |
| bank1_oe_n | output | 1 | Bank 1 output enable, active low |
| field_done | output | 1 | One-cycle field-complete pulse |
| field_len | output | ADDR_W | Bytes written into the completed field |
| field_bank | output | 1 | Bank holding the completed field |

## Verification
The hardest situation to reach is a field indicator change that arrives in the middle of an active run. The swap must then wait until two blanking samples have passed, and the last bytes of the line must still land in the old bank. The stimulus changes `field_raw` deliberately inside a long active burst, and random bursts also place field changes at arbitrary distances from the active edges. Saturation would take a million writes at the default width, so the bench builds the block with a 12-bit address and holds active video high past the limit.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int PIX_W = 10;
    localparam int MEM_W = 8;
    localparam int BANKS = 2;

    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_e;

    // One pending byte write toward the capture bank
    typedef struct packed {
        logic             en;
        logic [MEM_W-1:0] data;
    } wr_beat_t;

    // Field value 1 writes bank 0, field value 0 writes bank 1
    function automatic bank_e capture_bank(input logic fld);
        return fld ? BANK0 : BANK1;
    endfunction

    // Upper bits of a decoder word that fit one SRAM byte
    function automatic logic [MEM_W-1:0] keep_msbs(input logic [PIX_W-1:0] w);
        return w[PIX_W-1 -: MEM_W];
    endfunction

endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fpc_addr_gen.sv
module fpc_addr_gen
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_active,
    input  logic [PIX_W-1:0]  vid_word,
    input  logic              clear,
    output logic              act_q,
    output wr_beat_t          beat,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] LAST = '1;
    localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] base;
    logic              run_start;

    // A run starts on the first active sample after a blanking sample
    assign run_start = vid_active && !act_q;
    assign base      = run_start ? '0 : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            beat    <= '0;
            wr_addr <= '0;
            ptr     <= '0;
        end else begin
            act_q   <= vid_active;
            beat.en <= vid_active;
            if (vid_active) begin
                wr_addr   <= base;
                beat.data <= keep_msbs(vid_word);
                ptr       <= (base == LAST) ? LAST : base + ONE;
            end else if (clear) begin
                ptr <= '0;
            end
        end
    end

    assign next_addr = ptr;
endmodule

// File: rtl/fpc_swap_ctrl.sv
module fpc_swap_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_s,
    input  logic              vid_active,
    input  logic              act_q,
    input  logic [ADDR_W-1:0] next_addr,
    output bank_e             cap_bank,
    output logic              swap,
    output logic              done,
    output logic [ADDR_W-1:0] done_len,
    output bank_e             done_bank
);
    logic fld_q;

    // Two consecutive blanking samples guarantee no write is in flight
    assign swap     = (field_s != fld_q) && !vid_active && !act_q;
    assign cap_bank = capture_bank(fld_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_q     <= 1'b0;
            done      <= 1'b0;
            done_len  <= '0;
            done_bank <= BANK0;
        end else begin
            done <= swap;
            if (swap) begin
                fld_q     <= field_s;
                done_len  <= next_addr;
                done_bank <= capture_bank(fld_q);
            end
        end
    end
endmodule

// File: rtl/fpc_router.sv
module fpc_router
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  bank_e             cap_bank,
    input  wr_beat_t          beat,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_ce_n,
    input  logic              host_oe_n,
    input  logic [MEM_W-1:0]  mem_rdata [BANKS],
    output logic [ADDR_W-1:0] mem_addr  [BANKS],
    output logic [MEM_W-1:0]  mem_wdata [BANKS],
    output logic              mem_ce_n  [BANKS],
    output logic              mem_we_n  [BANKS],
    output logic              mem_oe_n  [BANKS],
    output logic [MEM_W-1:0]  host_rdata
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        localparam bank_e ME = (g == 0) ? BANK0 : BANK1;
        always_comb begin
            if (cap_bank == ME) begin
                mem_addr[g]  = wr_addr;
                mem_wdata[g] = beat.data;
                mem_ce_n[g]  = !beat.en;
                mem_we_n[g]  = !beat.en;
                mem_oe_n[g]  = 1'b1;
            end else begin
                mem_addr[g]  = host_addr;
                mem_wdata[g] = '0;
                mem_ce_n[g]  = host_ce_n;
                mem_we_n[g]  = 1'b1;
                mem_oe_n[g]  = host_oe_n;
            end
        end
    end

    assign host_rdata = (cap_bank == BANK0) ? mem_rdata[1] : mem_rdata[0];
endmodule

// File: rtl/field_pingpong_capture.sv
module field_pingpong_capture
    import fpc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_active,
    input  logic [PIX_W-1:0]  vid_word,
    input  logic              field_raw,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_ce_n,
    input  logic              host_oe_n,
    output logic [MEM_W-1:0]  host_rdata,
    output logic [ADDR_W-1:0] bank0_addr,
    output logic [MEM_W-1:0]  bank0_wdata,
    input  logic [MEM_W-1:0]  bank0_rdata,
    output logic              bank0_ce_n,
    output logic              bank0_we_n,
    output logic              bank0_oe_n,
    output logic [ADDR_W-1:0] bank1_addr,
    output logic [MEM_W-1:0]  bank1_wdata,
    input  logic [MEM_W-1:0]  bank1_rdata,
    output logic              bank1_ce_n,
    output logic              bank1_we_n,
    output logic              bank1_oe_n,
    output logic              field_done,
    output logic [ADDR_W-1:0] field_len,
    output logic              field_bank
);
    logic              field_s;
    logic              act_q;
    logic              swap;
    wr_beat_t          beat;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] next_addr;
    bank_e             cap_bank;
    bank_e             done_bank;

    logic [ADDR_W-1:0] m_addr  [BANKS];
    logic [MEM_W-1:0]  m_wdata [BANKS];
    logic [MEM_W-1:0]  m_rdata [BANKS];
    logic              m_ce_n  [BANKS];
    logic              m_we_n  [BANKS];
    logic              m_oe_n  [BANKS];

    fpc_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (field_raw),
        .q   (field_s)
    );

    fpc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .vid_active (vid_active),
        .vid_word   (vid_word),
        .clear      (swap),
        .act_q      (act_q),
        .beat       (beat),
        .wr_addr    (wr_addr),
        .next_addr  (next_addr)
    );

    fpc_swap_ctrl #(.ADDR_W(ADDR_W)) u_swap (
        .clk        (clk),
        .rst        (rst),
        .field_s    (field_s),
        .vid_active (vid_active),
        .act_q      (act_q),
        .next_addr  (next_addr),
        .cap_bank   (cap_bank),
        .swap       (swap),
        .done       (field_done),
        .done_len   (field_len),
        .done_bank  (done_bank)
    );

    assign m_rdata[0] = bank0_rdata;
    assign m_rdata[1] = bank1_rdata;

    fpc_router #(.ADDR_W(ADDR_W)) u_route (
        .cap_bank   (cap_bank),
        .beat       (beat),
        .wr_addr    (wr_addr),
        .host_addr  (host_addr),
        .host_ce_n  (host_ce_n),
        .host_oe_n  (host_oe_n),
        .mem_rdata  (m_rdata),
        .mem_addr   (m_addr),
        .mem_wdata  (m_wdata),
        .mem_ce_n   (m_ce_n),
        .mem_we_n   (m_we_n),
        .mem_oe_n   (m_oe_n),
        .host_rdata (host_rdata)
    );

    assign bank0_addr  = m_addr[0];
    assign bank0_wdata = m_wdata[0];
    assign bank0_ce_n  = m_ce_n[0];
    assign bank0_we_n  = m_we_n[0];
    assign bank0_oe_n  = m_oe_n[0];
    assign bank1_addr  = m_addr[1];
    assign bank1_wdata = m_wdata[1];
    assign bank1_ce_n  = m_ce_n[1];
    assign bank1_we_n  = m_we_n[1];
    assign bank1_oe_n  = m_oe_n[1];
    assign field_bank  = (done_bank == BANK1);
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              vid_active,
    input logic [ADDR_W-1:0] bank0_addr,
    input logic              bank0_ce_n,
    input logic              bank0_we_n,
    input logic              bank0_oe_n,
    input logic [ADDR_W-1:0] bank1_addr,
    input logic              bank1_ce_n,
    input logic              bank1_we_n,
    input logic              bank1_oe_n,
    input logic              field_done
);
    logic past_ok = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R4
    bank0_write_strobe_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !bank0_we_n |-> (!bank0_ce_n && bank0_oe_n));

    // R4
    bank1_write_strobe_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !bank1_we_n |-> (!bank1_ce_n && bank1_oe_n));

    // R1
    single_writer_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        bank0_we_n || bank1_we_n);

    // R5
    blank_no_write_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !vid_active |=> (bank0_we_n && bank1_we_n));

    // R3
    run_restart_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(vid_active) |=> ((!bank0_we_n && bank0_addr == '0) ||
                               (!bank1_we_n && bank1_addr == '0)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        field_done |=> !field_done);

    // R2
    swap_quiet_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        field_done |-> (bank0_we_n && bank1_we_n));
endmodule

bind field_pingpong_capture fpc_checker #(.ADDR_W(ADDR_W)) u_fpc_chk (
    .clk        (clk),
    .rst        (rst),
    .vid_active (vid_active),
    .bank0_addr (bank0_addr),
    .bank0_ce_n (bank0_ce_n),
    .bank0_we_n (bank0_we_n),
    .bank0_oe_n (bank0_oe_n),
    .bank1_addr (bank1_addr),
    .bank1_ce_n (bank1_ce_n),
    .bank1_we_n (bank1_we_n),
    .bank1_oe_n (bank1_oe_n),
    .field_done (field_done)
);

// File: tb/tb_field_pingpong_capture.sv
module tb_field_pingpong_capture;
    localparam int AW = 12;
    localparam logic [AW-1:0] TOP = '1;

    logic          clk = 1'b0;
    logic          rst;
    logic          vid_active;
    logic [9:0]    vid_word;
    logic          field_raw;
    logic [AW-1:0] host_addr;
    logic          host_ce_n, host_oe_n;
    logic [7:0]    host_rdata;
    logic [AW-1:0] bank0_addr, bank1_addr;
    logic [7:0]    bank0_wdata, bank1_wdata, bank0_rdata, bank1_rdata;
    logic          bank0_ce_n, bank0_we_n, bank0_oe_n;
    logic          bank1_ce_n, bank1_we_n, bank1_oe_n;
    logic          field_done, field_bank;
    logic [AW-1:0] field_len;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Each bank returns a distinct function of its address
    function automatic logic [7:0] mem_val(input int b, input logic [AW-1:0] a);
        return (b == 0) ? (a[7:0] ^ 8'h5A) : (a[7:0] ^ 8'hC3);
    endfunction

    assign bank0_rdata = mem_val(0, bank0_addr);
    assign bank1_rdata = mem_val(1, bank1_addr);

    field_pingpong_capture #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .vid_active(vid_active), .vid_word(vid_word),
        .field_raw(field_raw), .host_addr(host_addr), .host_ce_n(host_ce_n),
        .host_oe_n(host_oe_n), .host_rdata(host_rdata),
        .bank0_addr(bank0_addr), .bank0_wdata(bank0_wdata), .bank0_rdata(bank0_rdata),
        .bank0_ce_n(bank0_ce_n), .bank0_we_n(bank0_we_n), .bank0_oe_n(bank0_oe_n),
        .bank1_addr(bank1_addr), .bank1_wdata(bank1_wdata), .bank1_rdata(bank1_rdata),
        .bank1_ce_n(bank1_ce_n), .bank1_we_n(bank1_we_n), .bank1_oe_n(bank1_oe_n),
        .field_done(field_done), .field_len(field_len), .field_bank(field_bank)
    );

    // Reference state, defined by the requirements
    logic          m_s1 = 0, m_s2 = 0, m_fld = 0, m_actq = 0;
    logic          m_wen = 0, m_done = 0, m_rise = 0;
    logic [AW-1:0] m_ptr = 0, m_waddr = 0, m_len = 0;
    logic [7:0]    m_wdata = 0;
    int            m_dbank = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic model_update(input logic act, input logic [9:0] w, input logic f);
        logic          sw;
        logic [AW-1:0] base;
        sw     = (m_s2 != m_fld) && !act && !m_actq;   // R2 acceptance rule
        base   = (act && !m_actq) ? '0 : m_ptr;          // R3 restart
        m_rise = act && !m_actq;
        m_done = sw;
        if (sw) begin
            m_len   = m_ptr;
            m_dbank = m_fld ? 0 : 1;
        end
        m_wen = act;
        if (act) begin
            m_waddr = base;
            m_wdata = w[9:2];
            m_ptr   = (base == TOP) ? TOP : base + 1'b1;  // R6 saturation
        end else if (sw) begin
            m_ptr = '0;
        end
        if (sw) m_fld = m_s2;
        m_s2   = m_s1;
        m_s1   = f;
        m_actq = act;
    endtask

    task automatic check_all();
        int            cap;
        logic          c_ce, c_we, c_oe, h_ce, h_we, h_oe;
        logic [AW-1:0] c_addr, h_addr;
        logic [7:0]    c_data;
        cap = m_fld ? 0 : 1;
        if (cap == 0) begin
            c_ce = bank0_ce_n; c_we = bank0_we_n; c_oe = bank0_oe_n; c_addr = bank0_addr; c_data = bank0_wdata;
            h_ce = bank1_ce_n; h_we = bank1_we_n; h_oe = bank1_oe_n; h_addr = bank1_addr;
        end else begin
            c_ce = bank1_ce_n; c_we = bank1_we_n; c_oe = bank1_oe_n; c_addr = bank1_addr; c_data = bank1_wdata;
            h_ce = bank0_ce_n; h_we = bank0_we_n; h_oe = bank0_oe_n; h_addr = bank0_addr;
        end
        // R1: host side of the pair never writes
        chk("R1 host bank we_n", h_we, 1'b1);
        if (m_wen) begin
            chk("R4 capture strobes", {c_ce, c_we, c_oe}, 3'b001);
            chk(m_rise ? "R3 restart address" : (m_waddr == TOP ? "R6 saturated address" : "R4 write address"),
                c_addr, m_waddr);
            chk("R4 write data", c_data, m_wdata);
        end else begin
            chk("R5 no write when blank", {c_ce, c_we}, 2'b11);
        end
        // R7 host pass-through
        chk("R7 host addr", h_addr, host_addr);
        chk("R7 host ce/oe", {h_ce, h_oe}, {host_ce_n, host_oe_n});
        chk("R7 host rdata", host_rdata, mem_val(1 - cap, host_addr));
        // R8 and R2 completion pulse timing
        chk("R8 field_done", field_done, m_done);
        if (m_done) begin
            chk("R8 field_len", field_len, m_len);
            chk("R8 field_bank", field_bank, m_dbank[0]);
        end
    endtask

    task automatic step(input logic act, input logic [9:0] w, input logic f);
        vid_active = act;
        vid_word   = w;
        field_raw  = f;
        host_addr  = AW'($urandom);
        host_ce_n  = 1'($urandom);
        host_oe_n  = 1'($urandom);
        @(posedge clk);
        model_update(act, w, f);
        @(negedge clk);
        check_all();
    endtask

    // Blanking codes, active words, blanking codes
    task automatic line(input int n, input logic f);
        for (int i = 0; i < 4; i++) step(1'b0, (i == 0) ? 10'h3FF : ((i == 3) ? 10'h200 : 10'h000), f);
        for (int i = 0; i < n; i++) step(1'b1, 10'($urandom), f);
        for (int i = 0; i < 4; i++) step(1'b0, (i == 0) ? 10'h3FF : 10'h000, f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: all requirements, actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1; vid_active = 1'b0; vid_word = '0; field_raw = 1'b0;
        host_addr = '0; host_ce_n = 1'b1; host_oe_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state: bank 1 captures, strobes idle, no completion
        chk("R9 bank1 strobes in reset", {bank1_ce_n, bank1_we_n, bank1_oe_n}, 3'b111);
        chk("R9 field_done in reset", field_done, 1'b0);
        rst = 1'b0;
        step(1'b0, 10'h000, 1'b0);
        chk("R9 bank1 idle after reset", {bank1_ce_n, bank1_we_n}, 2'b11);

        // R3 R4 R5: two lines, second restarts at zero
        line(16, 1'b0);
        line(10, 1'b0);
        // R2 R8: field change during blanking, 10 bytes reported from bank 1
        for (int i = 0; i < 6; i++) step(1'b0, 10'h000, 1'b1);
        // R1: now bank 0 captures
        line(8, 1'b1);
        // R2: field changes mid-run; swap waits for blanking
        for (int i = 0; i < 5; i++) step(1'b1, 10'($urandom), 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, 10'($urandom), 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 10'h000, 1'b0);
        // R8: empty field reports zero
        for (int i = 0; i < 6; i++) step(1'b0, 10'h000, 1'b1);

        // Random bursts with random field changes
        begin
            logic f;
            f = 1'b1;
            for (int k = 0; k < 300; k++) begin
                int n;
                n = int'($urandom % 40);
                if ($urandom % 4 == 0) f = ~f;
                for (int i = 0; i < n; i++) step(1'b1, 10'($urandom), f);
                n = 1 + int'($urandom % 6);
                for (int i = 0; i < n; i++) step(1'b0, 10'($urandom), f);
            end
            // R6: one long run past the top of the address space
            for (int i = 0; i < 6; i++) step(1'b0, 10'h000, f);
            for (int i = 0; i < int'(TOP) + 8; i++) step(1'b1, 10'($urandom), f);
            for (int i = 0; i < 6; i++) step(1'b0, 10'h000, ~f);
            chk("R6 saturated length seen", m_len, TOP);
        end

        summary();
        $finish;
    end
endmodule